// File: doc/BRIEF.md
# Time-Shared Control-Voltage and Gate Output Scanner

This block refreshes eight control-voltage outputs from a single shared DAC. It keeps one 8-bit code per channel, written through a simple register write port. It visits the channels in a fixed round-robin. For each channel it drives a 3-bit select to an external analog demultiplexer and presents that channel's code to the DAC pins. Late in the channel's time slot, once the converter output has had time to settle, it pulses a sample strobe so the selected hold circuit captures the voltage. One code step stands for one semitone, which is 1/12 V at the analog side.

The block also keeps four gate bits and four multiplex-control bits. Software writes them into a staging register. They are copied to the output latch once per full scan, when the channel 0 slot begins, so all eight bits change together on a known scan boundary.

Top module: `cvs_scanner`

## Requirements
- R1: While rst_ni is low, chan_sel_o, dac_code_o, sample_o, gate_o and mpx_o are all zero.
- R2: Each slot lasts SLOT_CYCLES clocks. chan_sel_o steps through 0,1,...,7 and then wraps to 0, and the first slot after reset is channel 0.
- R3: For the whole of a slot, dac_code_o equals the code that the slot's channel held when the slot began. dac_code_o changes only on the first clock of a slot.
- R4: sample_o is high during exactly the last STROBE_CYCLES clocks of every slot and low during all other clocks.
- R5: A write with wr_addr_i[3]=0 stores wr_data_i as the code of channel wr_addr_i[2:0]. It shows on dac_code_o from the next start of that channel's slot. A write during that channel's own slot does not change the current slot.
- R6: A write with wr_addr_i[3]=1 stages gate bits from wr_data_i[3:0] and multiplex bits from wr_data_i[7:4]. gate_o and mpx_o take the staged value only when a channel 0 slot begins, and hold it otherwise.
- R7: The code path is a straight copy. Every value from 0x00 to 0xFF reaches dac_code_o unchanged, with one LSB per semitone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one clock per write |
| wr_addr_i | input | 4 | Bit 3 set: gate/mpx register. Clear: CV channel in bits 2:0 |
| wr_data_i | input | 8 | Write data |
| chan_sel_o | output | 3 | Demultiplexer channel select |
| dac_code_o | output | 8 | Code presented to the DAC |
| sample_o | output | 1 | Sample-and-hold strobe for the selected channel |
| gate_o | output | 4 | Latched gate outputs |
| mpx_o | output | 4 | Latched multiplex-control outputs |

## Verification
The assertions assume that STROBE_CYCLES is smaller than SLOT_CYCLES, so the strobe never covers a slot's first clock. They also assume every write input is steady around the rising edge. The bench changes all inputs on the falling edge and keeps the default slot timing. It places writes at random cycles, which covers the last clock of a slot, a channel's own slot, and gate writes made just before channel 0 comes round. It also writes the extreme codes 0x00 and 0xFF.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  localparam int GM_LINES = 4;

  typedef struct packed {
    logic [GM_LINES-1:0] mpx;
    logic [GM_LINES-1:0] gate;
  } gm_word_t;
endpackage

// File: rtl/cvs_regfile.sv
module cvs_regfile #(
  parameter int CHANNELS = 8,
  parameter int CODE_W   = 8,
  localparam int CH_W    = $clog2(CHANNELS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CH_W-1:0]   waddr_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic [CH_W-1:0]   raddr_i,
  output logic [CODE_W-1:0] rdata_o
);
  logic [CODE_W-1:0] code_q [CHANNELS];

  for (genvar g = 0; g < CHANNELS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) code_q[g] <= '0;
      else if (we_i && waddr_i == CH_W'(g)) code_q[g] <= wdata_i;
    end
  end

  assign rdata_o = code_q[raddr_i];
endmodule

// File: rtl/cvs_slot_timer.sv
module cvs_slot_timer #(
  parameter int CHANNELS      = 8,
  parameter int SLOT_CYCLES   = 8,
  parameter int STROBE_CYCLES = 2,
  localparam int CH_W         = $clog2(CHANNELS),
  localparam int CNT_W        = $clog2(SLOT_CYCLES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [CH_W-1:0] chan_o,
  output logic [CH_W-1:0] next_chan_o,
  output logic            slot_last_o,
  output logic            slot_first_o,
  output logic            strobe_o
);
  localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(SLOT_CYCLES - 1);
  localparam logic [CNT_W-1:0] STROBE_BEG = CNT_W'(SLOT_CYCLES - STROBE_CYCLES);
  localparam logic [CH_W-1:0]  CH_LAST    = CH_W'(CHANNELS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  chan_q;

  assign slot_last_o  = (cnt_q == CNT_LAST);
  assign slot_first_o = (cnt_q == '0);
  assign next_chan_o  = (chan_q == CH_LAST) ? '0 : chan_q + 1'b1;
  assign chan_o       = chan_q;
  assign strobe_o     = (cnt_q >= STROBE_BEG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      chan_q <= '0;
    end else if (slot_last_o) begin
      cnt_q  <= '0;
      chan_q <= next_chan_o;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST); // R2
  AST_CHAN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_q != $past(chan_q)) |->
      (chan_q == (($past(chan_q) == CH_LAST) ? '0 : $past(chan_q) + 1'b1))); // R2
  AST_CHAN_ONLY_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> $stable(chan_q)); // R2
endmodule

// File: rtl/cvs_gate_latch.sv
module cvs_gate_latch
  import cvs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     stage_we_i,
  input  gm_word_t stage_d_i,
  input  logic     load_i,
  output gm_word_t out_o
);
  gm_word_t stage_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      if (stage_we_i) stage_q <= stage_d_i;
      if (load_i)     out_q   <= stage_q;
    end
  end

  assign out_o = out_q;

  AST_GM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> $stable(out_q)); // R6
endmodule

// File: rtl/cvs_scanner.sv
module cvs_scanner
  import cvs_pkg::*;
#(
  parameter int CHANNELS      = 8,
  parameter int CODE_W        = 8,
  parameter int SLOT_CYCLES   = 8,
  parameter int STROBE_CYCLES = 2,
  localparam int CH_W         = $clog2(CHANNELS),
  localparam int ADDR_W       = CH_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [CODE_W-1:0]   wr_data_i,
  output logic [CH_W-1:0]     chan_sel_o,
  output logic [CODE_W-1:0]   dac_code_o,
  output logic                sample_o,
  output logic [GM_LINES-1:0] gate_o,
  output logic [GM_LINES-1:0] mpx_o
);
  logic              cv_we, gm_we;
  logic [CH_W-1:0]   chan, next_chan;
  logic              slot_last, slot_first, strobe;
  logic [CODE_W-1:0] rd_code;
  logic [CODE_W-1:0] dac_q;
  gm_word_t          gm_out;

  assign cv_we = wr_en_i && !wr_addr_i[ADDR_W-1];
  assign gm_we = wr_en_i &&  wr_addr_i[ADDR_W-1];

  cvs_regfile #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) u_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cv_we),
    .waddr_i (wr_addr_i[CH_W-1:0]),
    .wdata_i (wr_data_i),
    .raddr_i (next_chan),
    .rdata_o (rd_code)
  );

  cvs_slot_timer #(
    .CHANNELS(CHANNELS), .SLOT_CYCLES(SLOT_CYCLES), .STROBE_CYCLES(STROBE_CYCLES)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .chan_o       (chan),
    .next_chan_o  (next_chan),
    .slot_last_o  (slot_last),
    .slot_first_o (slot_first),
    .strobe_o     (strobe)
  );

  // code for the coming slot is captured on the boundary edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dac_q <= '0;
    else if (slot_last) dac_q <= rd_code;
  end

  cvs_gate_latch u_gm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stage_we_i (gm_we),
    .stage_d_i  (gm_word_t'(wr_data_i[2*GM_LINES-1:0])),
    .load_i     (slot_last && next_chan == '0),
    .out_o      (gm_out)
  );

  assign chan_sel_o = chan;
  assign dac_code_o = dac_q;
  assign sample_o   = strobe;
  assign gate_o     = gm_out.gate;
  assign mpx_o      = gm_out.mpx;

  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_first |-> $stable(dac_code_o)); // R3
  AST_STROBE_OFF_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_first |-> !sample_o); // R4
  AST_GM_AT_CH0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slot_first && chan_sel_o == '0) |-> ($stable(gate_o) && $stable(mpx_o))); // R6
  AST_STROBE_PARAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    STROBE_CYCLES < SLOT_CYCLES); // R4
endmodule

// File: tb/cvs_scanner_bench.sv
module cvs_scanner_bench;
  localparam int S  = 8;
  localparam int ST = 2;
  localparam int WATCHDOG_CYC = 100000;

  typedef struct {
    int chan;
    int code;
    int gate;
    int mpx;
  } exp_t;

  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic       wr_en_i = 0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] chan_sel_o;
  logic [7:0] dac_code_o;
  logic       sample_o;
  logic [3:0] gate_o, mpx_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  exp_t q[$];
  exp_t cur;
  int   pc = 0;
  int   ref_cv [8];
  int   ref_stage = 0;
  int   ref_out = 0;

  always #2.5 clk_i = ~clk_i;

  cvs_scanner #(.SLOT_CYCLES(S), .STROBE_CYCLES(ST)) u_cvs_scanner (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .chan_sel_o(chan_sel_o), .dac_code_o(dac_code_o),
    .sample_o(sample_o), .gate_o(gate_o), .mpx_o(mpx_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // predictor: pushes the expected content of each slot at its start edge
  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (pc % S == S - 1) begin
        exp_t e;
        e.chan = ((pc / S) + 1) % 8;
        e.code = ref_cv[e.chan];
        if (e.chan == 0) ref_out = ref_stage;
        e.gate = ref_out & 15;
        e.mpx  = (ref_out >> 4) & 15;
        q.push_back(e);
      end
      if (wr_en_i) begin
        if (wr_addr_i[3]) ref_stage = int'(wr_data_i);
        else ref_cv[wr_addr_i[2:0]] = int'(wr_data_i);
      end
      pc++;
    end
  end

  // monitor
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      chk("R1", "chan_sel", int'(chan_sel_o), 0);
      chk("R1", "dac_code", int'(dac_code_o), 0);
      chk("R1", "sample", int'(sample_o), 0);
      chk("R1", "gate", int'(gate_o), 0);
      chk("R1", "mpx", int'(mpx_o), 0);
    end else if (!done) begin
      if (pc % S == 0) begin
        if (q.size() == 0) chk("R3", "queue empty at slot start", 0, 1);
        else cur = q.pop_front();
      end
      chk("R2", "chan_sel", int'(chan_sel_o), (pc / S) % 8);
      chk("R2", "chan vs scoreboard", int'(chan_sel_o), cur.chan);
      chk("R4", "sample", int'(sample_o), (pc % S >= S - ST) ? 1 : 0);
      chk("R5", "dac_code", int'(dac_code_o), cur.code);
      chk("R6", "gate", int'(gate_o), cur.gate);
      chk("R6", "mpx", int'(mpx_o), cur.mpx);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    exp_t e0;
    foreach (ref_cv[i]) ref_cv[i] = 0;
    e0.chan = 0; e0.code = 0; e0.gate = 0; e0.mpx = 0;
    q.push_back(e0);
    idle(4);
    rst_ni = 1;
    // R2 R4: scan with all-zero codes
    idle(3 * 8 * S);
    // R7: extreme and distinct codes on every channel
    for (int c = 0; c < 8; c++) wr({1'b0, 3'(c)}, 8'(c * 33 + 7));
    wr(4'h2, 8'hFF);
    wr(4'h5, 8'h00);
    idle(2 * 8 * S);
    // R5: write channel 3 while its own slot runs
    while (!(chan_sel_o == 3'd3 && sample_o == 0)) @(negedge clk_i);
    wr(4'h3, 8'hA5);
    idle(2 * 8 * S);
    // R6: gate/mpx staged mid-scan, then just before channel 0
    wr(4'h8, 8'h9C);
    idle(8 * S);
    while (!(chan_sel_o == 3'd7 && sample_o == 1)) @(negedge clk_i);
    wr(4'hF, 8'h36);
    idle(2 * 8 * S);
    // mixed random traffic, including writes on slot boundaries
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 2) == 0) wr(4'($urandom_range(0, 15)), 8'($urandom));
      else idle($urandom_range(1, 5));
    end
    idle(2 * 8 * S);
    done = 1;
    idle(1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule